// File: doc/BRIEF.md
# Memory Request Admission Queues

This block sits at the entry of a DRAM controller and decides which requests get in. One request per cycle arrives on a valid/ready interface. Every request is one burst long and is either a read or a write. Accepted writes go into a write queue and are acknowledged at once. Accepted reads go into a read queue, unless a queued write already holds the same address; such a read is answered on the spot by a forwarding pulse and never reaches the read queue. Each entry carries the full address and the column, bank, rank and row decoded from it, so a later scheduler can work from the queue heads without decoding again.

The downstream scheduler pops the read head when it issues that read. The read then becomes an outstanding response until `rsp_done_i` reports it finished. Queued reads and outstanding responses share one capacity limit. Pops on the write side simply free write slots. A request refused because its queue is full is remembered per direction, and the requester gets a single retry pulse when a slot of that kind frees up. When the write queue holds more entries than a threshold, and reads are not stalled, a drain request is raised. A request marked inhibited is accepted and thrown away.

Top module: `mem_req_admit`

## Requirements
- R1: After reset both queues are empty, `req_ready_o` is high for any request, both head-valid outputs are low, and `wr_ack_o`, `rd_fwd_o`, `rd_retry_o`, `wr_retry_o` and `drain_req_o` are low.
- R2: With the default geometry (64-byte bursts), the address is divided by the burst size and the fields are taken from the quotient. Column is address bits 12:6, bank is bits 15:13, rank is bit 16 and row is bits 31:17. These fields appear on the head outputs beside the unmodified address.
- R3: A read is refused (`req_ready_o` low) exactly when the queued reads plus the outstanding responses equal `RD_DEPTH`, as counted after the previous clock edge. That sum never exceeds `RD_DEPTH`.
- R4: A write is refused exactly when the write queue holds `WR_DEPTH` entries, as counted after the previous clock edge.
- R5: A refused request changes no queue and sets the retry flag of its direction.
- R6: When `rsp_done_i` releases an outstanding response while the read retry flag is set, `rd_retry_o` is high for one cycle after that edge and the flag clears. A refusal in that same cycle sets the flag again.
- R7: When `wr_pop_i` removes a write while the write retry flag is set, `wr_retry_o` is high for one cycle after that edge and the flag clears.
- R8: An accepted read whose address equals that of any write held in the write queue at that edge is not queued. `rd_fwd_o` pulses one cycle later with that address on `rd_fwd_addr_o`.
- R9: Every accepted write produces a one-cycle `wr_ack_o` pulse in the cycle after its acceptance edge, whether or not it has been popped.
- R10: `drain_req_o`, registered, is high in the cycle after an edge exactly when the write occupancy after that edge is greater than `WR_THRESH` and `rd_stall_i` was low at that edge.
- R11: A request with `req_inhibit_i` high is always accepted and leaves both queues, all pulses and the retry flags unchanged.
- R12: Each queue hands out entries in arrival order. A push and a pop in the same cycle leave the occupancy unchanged. A pop of an empty queue and a release with no outstanding response are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_inhibit_i | input | 1 | Request to be accepted and discarded |
| req_addr_i | input | ADDR_W | Byte address of the burst |
| req_ready_o | output | 1 | Request of the presented kind would be accepted |
| rd_stall_i | input | 1 | Reads stalled; suppresses the drain request |
| rd_pop_i | input | 1 | Scheduler issues the read head |
| rsp_done_i | input | 1 | One outstanding read response finished |
| wr_pop_i | input | 1 | Scheduler issues the write head |
| rd_head_valid_o | output | 1 | Read queue not empty |
| rd_head_addr_o | output | ADDR_W | Address of oldest read |
| rd_head_col_o | output | COL_W | Column of oldest read |
| rd_head_bank_o | output | BANK_W | Bank of oldest read |
| rd_head_rank_o | output | RANK_W | Rank of oldest read |
| rd_head_row_o | output | ROW_W | Row of oldest read |
| wr_head_valid_o | output | 1 | Write queue not empty |
| wr_head_addr_o | output | ADDR_W | Address of oldest write |
| wr_head_col_o | output | COL_W | Column of oldest write |
| wr_head_bank_o | output | BANK_W | Bank of oldest write |
| wr_head_rank_o | output | RANK_W | Rank of oldest write |
| wr_head_row_o | output | ROW_W | Row of oldest write |
| wr_ack_o | output | 1 | Write accepted pulse |
| rd_fwd_o | output | 1 | Read answered from write queue pulse |
| rd_fwd_addr_o | output | ADDR_W | Address of the forwarded read |
| rd_retry_o | output | 1 | Retry pulse for a refused read |
| wr_retry_o | output | 1 | Retry pulse for a refused write |
| drain_req_o | output | 1 | Write queue above threshold |

## Verification
Two functions can land on the same clock edge: a read is refused because the shared read capacity is full, and `rsp_done_i` releases a response slot. The bench fills the read side to capacity, then drives a read together with `rsp_done_i`. It expects a refusal, a retry pulse on the next cycle and the flag still set, so that a second release gives another pulse and a third gives none. It also pairs an accepted read with a release, and an accepted write with a write pop, and checks that occupancy stays level. A scoreboard model predicts readiness, heads, pulses and the drain level every cycle.

// File: rtl/adm_pkg.sv
package adm_pkg;

    typedef enum logic [1:0] {
        REQ_NONE  = 2'd0,
        REQ_READ  = 2'd1,
        REQ_WRITE = 2'd2,
        REQ_DROP  = 2'd3
    } req_kind_e;

endpackage

// File: rtl/adm_decode.sv
module adm_decode #(
    parameter int COL_W  = 7,
    parameter int BANK_W = 3,
    parameter int RANK_W = 1,
    parameter int ROW_W  = 15,
    localparam int LINE_W = COL_W + BANK_W + RANK_W + ROW_W
) (
    input  logic [LINE_W-1:0] line_i,
    output logic [COL_W-1:0]  col_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [RANK_W-1:0] rank_o,
    output logic [ROW_W-1:0]  row_o
);
    localparam int BANK_LO = COL_W;
    localparam int RANK_LO = BANK_LO + BANK_W;
    localparam int ROW_LO  = RANK_LO + RANK_W;

    // column in the low bits, then bank, then rank, row on top
    assign col_o  = line_i[0 +: COL_W];
    assign bank_o = line_i[BANK_LO +: BANK_W];
    assign rank_o = line_i[RANK_LO +: RANK_W];
    assign row_o  = line_i[ROW_LO +: ROW_W];
endmodule

// File: rtl/adm_queue.sv
module adm_queue #(
    parameter int DEPTH    = 8,
    parameter int W        = 8,
    parameter int KEY_W    = 8,
    parameter bit MATCH_EN = 1'b0,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic [W-1:0]     data_i,
    input  logic             pop_i,
    input  logic [KEY_W-1:0] key_i,
    output logic [W-1:0]     head_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] rptr;
        logic [PTR_W-1:0] wptr;
        logic [CNT_W-1:0] cnt;
        logic [DEPTH-1:0] vld;
    } qstate_t;

    qstate_t    st_q, st_d;
    logic [W-1:0] mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.wptr           = step_ptr(st_q.wptr);
            st_d.vld[st_q.wptr] = 1'b1;
        end
        if (pop_i) begin
            st_d.rptr           = step_ptr(st_q.rptr);
            st_d.vld[st_q.rptr] = 1'b0;
        end
        st_d.cnt = st_q.cnt + CNT_W'(push_i) - CNT_W'(pop_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_ff @(posedge clk_i) begin
        if (push_i) mem_q[st_q.wptr] <= data_i;
    end

    assign head_o = mem_q[st_q.rptr];
    assign cnt_o  = st_q.cnt;

    generate
        if (MATCH_EN) begin : g_match
            logic [DEPTH-1:0] eq;
            for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
                assign eq[i] = st_q.vld[i] && (mem_q[i][KEY_W-1:0] == key_i);
            end
            assign hit_o = |eq;
        end else begin : g_nomatch
            // this variant never compares; the key is folded away
            assign hit_o = 1'b0 & (^key_i);
        end
    endgenerate

    p_no_overflow_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_i |-> (st_q.cnt < CNT_W'(DEPTH)));
    p_no_underflow_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_i |-> (st_q.cnt != '0));
    p_level_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && pop_i) |=> $stable(cnt_o));
endmodule

// File: rtl/mem_req_admit.sv
module mem_req_admit #(
    parameter int ADDR_W      = 32,
    parameter int BURST_BYTES = 64,
    parameter int COL_W       = 7,
    parameter int BANK_W      = 3,
    parameter int RANK_W      = 1,
    parameter int ROW_W       = 15,
    parameter int RD_DEPTH    = 8,
    parameter int WR_DEPTH    = 8,
    parameter int WR_THRESH   = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic              req_inhibit_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              req_ready_o,
    input  logic              rd_stall_i,
    input  logic              rd_pop_i,
    input  logic              rsp_done_i,
    input  logic              wr_pop_i,
    output logic              rd_head_valid_o,
    output logic [ADDR_W-1:0] rd_head_addr_o,
    output logic [COL_W-1:0]  rd_head_col_o,
    output logic [BANK_W-1:0] rd_head_bank_o,
    output logic [RANK_W-1:0] rd_head_rank_o,
    output logic [ROW_W-1:0]  rd_head_row_o,
    output logic              wr_head_valid_o,
    output logic [ADDR_W-1:0] wr_head_addr_o,
    output logic [COL_W-1:0]  wr_head_col_o,
    output logic [BANK_W-1:0] wr_head_bank_o,
    output logic [RANK_W-1:0] wr_head_rank_o,
    output logic [ROW_W-1:0]  wr_head_row_o,
    output logic              wr_ack_o,
    output logic              rd_fwd_o,
    output logic [ADDR_W-1:0] rd_fwd_addr_o,
    output logic              rd_retry_o,
    output logic              wr_retry_o,
    output logic              drain_req_o
);
    import adm_pkg::*;

    localparam int OFF_W  = $clog2(BURST_BYTES);
    localparam int LINE_W = COL_W + BANK_W + RANK_W + ROW_W;
    localparam int RD_CW  = $clog2(RD_DEPTH + 1);
    localparam int WR_CW  = $clog2(WR_DEPTH + 1);
    localparam int RT_W   = RD_CW + 1;

    generate
        if (BURST_BYTES != 32 && BURST_BYTES != 64) begin : g_bad_burst
            $error("burst size must be 32 or 64 bytes");
        end
        if (OFF_W + LINE_W > ADDR_W) begin : g_bad_geom
            $error("decoded fields exceed the address width");
        end
    endgenerate

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [RANK_W-1:0] rank;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [ADDR_W-1:0] addr;
    } entry_t;
    localparam int ENT_W = $bits(entry_t);

    typedef struct packed {
        logic [RD_CW-1:0]  rsp;
        logic              rd_full;
        logic              wr_full;
        logic              rd_flag;
        logic              wr_flag;
        logic              rd_retry;
        logic              wr_retry;
        logic              wr_ack;
        logic              fwd;
        logic [ADDR_W-1:0] fwd_addr;
        logic              drain;
    } ctl_t;

    ctl_t       st_q, st_d;
    entry_t     new_ent, rd_head, wr_head;
    logic [RD_CW-1:0] rd_cnt;
    logic [WR_CW-1:0] wr_cnt, wr_cnt_n;
    logic [RD_CW-1:0] rd_cnt_n;
    logic [RT_W-1:0]  rd_total;
    logic       wr_hit, rd_hit_unused;
    logic       rd_push, wr_push, rd_pop_eff, wr_pop_eff, rsp_free;
    logic       rd_acc, wr_acc, rd_rej, wr_rej, fwd_take;
    req_kind_e  kind;

    adm_decode #(
        .COL_W (COL_W),
        .BANK_W(BANK_W),
        .RANK_W(RANK_W),
        .ROW_W (ROW_W)
    ) u_decode (
        .line_i(req_addr_i[OFF_W +: LINE_W]),
        .col_o (new_ent.col),
        .bank_o(new_ent.bank),
        .rank_o(new_ent.rank),
        .row_o (new_ent.row)
    );
    assign new_ent.addr = req_addr_i;

    adm_queue #(
        .DEPTH(RD_DEPTH), .W(ENT_W), .KEY_W(ADDR_W), .MATCH_EN(1'b0)
    ) u_rd_queue (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .push_i(rd_push),
        .data_i(new_ent),
        .pop_i (rd_pop_eff),
        .key_i (req_addr_i),
        .head_o(rd_head),
        .cnt_o (rd_cnt),
        .hit_o (rd_hit_unused)
    );

    adm_queue #(
        .DEPTH(WR_DEPTH), .W(ENT_W), .KEY_W(ADDR_W), .MATCH_EN(1'b1)
    ) u_wr_queue (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .push_i(wr_push),
        .data_i(new_ent),
        .pop_i (wr_pop_eff),
        .key_i (req_addr_i),
        .head_o(wr_head),
        .cnt_o (wr_cnt),
        .hit_o (wr_hit)
    );

    always_comb begin
        st_d = st_q;

        kind = REQ_NONE;
        if (req_valid_i) begin
            if (req_inhibit_i)    kind = REQ_DROP;
            else if (req_write_i) kind = REQ_WRITE;
            else                  kind = REQ_READ;
        end

        rd_acc   = (kind == REQ_READ)  && !st_q.rd_full;
        rd_rej   = (kind == REQ_READ)  &&  st_q.rd_full;
        wr_acc   = (kind == REQ_WRITE) && !st_q.wr_full;
        wr_rej   = (kind == REQ_WRITE) &&  st_q.wr_full;
        fwd_take = rd_acc && wr_hit && !rd_hit_unused;
        rd_push  = rd_acc && !wr_hit;
        wr_push  = wr_acc;

        rd_pop_eff = rd_pop_i   && (rd_cnt != '0);
        wr_pop_eff = wr_pop_i   && (wr_cnt != '0);
        rsp_free   = rsp_done_i && (st_q.rsp != '0);

        // occupancy after this edge, pushes and pops taken together
        st_d.rsp = st_q.rsp + RD_CW'(rd_pop_eff) - RD_CW'(rsp_free);
        rd_cnt_n = rd_cnt + RD_CW'(rd_push) - RD_CW'(rd_pop_eff);
        wr_cnt_n = wr_cnt + WR_CW'(wr_push) - WR_CW'(wr_pop_eff);
        rd_total = RT_W'(rd_cnt_n) + RT_W'(st_d.rsp);

        st_d.rd_full = (rd_total == RT_W'(RD_DEPTH));
        st_d.wr_full = (wr_cnt_n == WR_CW'(WR_DEPTH));

        st_d.rd_retry = st_q.rd_flag && rsp_free;
        st_d.wr_retry = st_q.wr_flag && wr_pop_eff;
        st_d.rd_flag  = (st_q.rd_flag && !rsp_free)   || rd_rej;
        st_d.wr_flag  = (st_q.wr_flag && !wr_pop_eff) || wr_rej;

        st_d.wr_ack = wr_push;
        st_d.fwd    = fwd_take;
        if (fwd_take) st_d.fwd_addr = req_addr_i;

        st_d.drain = (wr_cnt_n > WR_CW'(WR_THRESH)) && !rd_stall_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign req_ready_o     = req_inhibit_i || (req_write_i ? !st_q.wr_full : !st_q.rd_full);
    assign rd_head_valid_o = (rd_cnt != '0);
    assign rd_head_addr_o  = rd_head.addr;
    assign rd_head_col_o   = rd_head.col;
    assign rd_head_bank_o  = rd_head.bank;
    assign rd_head_rank_o  = rd_head.rank;
    assign rd_head_row_o   = rd_head.row;
    assign wr_head_valid_o = (wr_cnt != '0);
    assign wr_head_addr_o  = wr_head.addr;
    assign wr_head_col_o   = wr_head.col;
    assign wr_head_bank_o  = wr_head.bank;
    assign wr_head_rank_o  = wr_head.rank;
    assign wr_head_row_o   = wr_head.row;
    assign wr_ack_o        = st_q.wr_ack;
    assign rd_fwd_o        = st_q.fwd;
    assign rd_fwd_addr_o   = st_q.fwd_addr;
    assign rd_retry_o      = st_q.rd_retry;
    assign wr_retry_o      = st_q.wr_retry;
    assign drain_req_o     = st_q.drain;

    p_rd_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (RT_W'(rd_cnt) + RT_W'(st_q.rsp)) <= RT_W'(RD_DEPTH));
    p_wr_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_cnt <= WR_CW'(WR_DEPTH));
    p_refuse_no_push_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !req_inhibit_i && !req_ready_o) |=>
        (rd_cnt <= $past(rd_cnt) && wr_cnt <= $past(wr_cnt)));
    p_rd_retry_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_retry_o |-> $past(rsp_done_i));
    p_wr_retry_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_retry_o |-> $past(wr_pop_i && wr_head_valid_o));
    p_fwd_needs_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_fwd_o |-> $past(wr_head_valid_o && req_valid_i && !req_write_i));
    p_ack_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_ack_o |-> $past(req_valid_i && req_write_i && !req_inhibit_i && req_ready_o));
    p_drain_level_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drain_req_o |-> (wr_cnt > WR_CW'(WR_THRESH)) && !$past(rd_stall_i));
    p_drop_no_push_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_inhibit_i) |=>
        (rd_cnt <= $past(rd_cnt) && wr_cnt <= $past(wr_cnt) && !wr_ack_o && !rd_fwd_o));
endmodule

// File: tb/mem_req_admit_bench.sv
module mem_req_admit_bench;
    localparam int RD = 8;
    localparam int WD = 8;
    localparam int WT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_inh = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rd_stall = 1'b0, rd_pop = 1'b0, rsp_done = 1'b0, wr_pop = 1'b0;
    logic        req_ready_o;
    logic        rd_head_valid_o, wr_head_valid_o;
    logic [31:0] rd_head_addr_o, wr_head_addr_o, rd_fwd_addr_o;
    logic [6:0]  rd_head_col_o, wr_head_col_o;
    logic [2:0]  rd_head_bank_o, wr_head_bank_o;
    logic [0:0]  rd_head_rank_o, wr_head_rank_o;
    logic [14:0] rd_head_row_o, wr_head_row_o;
    logic        wr_ack_o, rd_fwd_o, rd_retry_o, wr_retry_o, drain_req_o;

    always #5 clk = ~clk;

    mem_req_admit u_mem_req_admit (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_inhibit_i(req_inh),
        .req_addr_i(req_addr), .req_ready_o(req_ready_o),
        .rd_stall_i(rd_stall), .rd_pop_i(rd_pop), .rsp_done_i(rsp_done), .wr_pop_i(wr_pop),
        .rd_head_valid_o(rd_head_valid_o), .rd_head_addr_o(rd_head_addr_o),
        .rd_head_col_o(rd_head_col_o), .rd_head_bank_o(rd_head_bank_o),
        .rd_head_rank_o(rd_head_rank_o), .rd_head_row_o(rd_head_row_o),
        .wr_head_valid_o(wr_head_valid_o), .wr_head_addr_o(wr_head_addr_o),
        .wr_head_col_o(wr_head_col_o), .wr_head_bank_o(wr_head_bank_o),
        .wr_head_rank_o(wr_head_rank_o), .wr_head_row_o(wr_head_row_o),
        .wr_ack_o(wr_ack_o), .rd_fwd_o(rd_fwd_o), .rd_fwd_addr_o(rd_fwd_addr_o),
        .rd_retry_o(rd_retry_o), .wr_retry_o(wr_retry_o), .drain_req_o(drain_req_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // scoreboard model
    logic [31:0] rd_q[$];
    logic [31:0] wr_q[$];
    logic [31:0] exp_fwd[$];
    int  exp_ack = 0;
    int  rsp_n = 0;
    bit  rflag = 1'b0, wflag = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int row, input int rank, input int bank,
                                        input int col, input int off);
        return (32'(row) << 17) | (32'(rank) << 16) | (32'(bank) << 13)
             | (32'(col) << 6) | 32'(off);
    endfunction

    // monitor: compares acknowledge and forwarding pulses with expected items
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (wr_ack_o) begin
                    chk(exp_ack > 0, "R9 unexpected ack", 1, 0);
                    if (exp_ack > 0) exp_ack--;
                end
                if (rd_fwd_o) begin
                    chk(exp_fwd.size() > 0, "R8 unexpected forward", 1, 0);
                    if (exp_fwd.size() > 0) begin
                        logic [31:0] e;
                        e = exp_fwd.pop_front();
                        chk(rd_fwd_addr_o == e, "R8 forward address", rd_fwd_addr_o, e);
                    end
                end
            end
        end
    end

    task automatic cyc(input bit v, input bit w, input bit inh, input logic [31:0] a,
                       input bit rp, input bit rdn, input bit wp);
        bit exp_rdy, got, hit, rfree, wfree, exp_rr, exp_wr, rej_r, rej_w;
        req_valid = v; req_write = w; req_inh = inh; req_addr = a;
        rd_pop = rp; rsp_done = rdn; wr_pop = wp;
        #2;
        got = req_ready_o;
        exp_rdy = inh ? 1'b1 : (w ? (wr_q.size() < WD) : ((rd_q.size() + rsp_n) < RD));
        if (v) chk(got == exp_rdy, inh ? "R11 ready" : (!exp_rdy ? "R5 refuse" : (w ? "R4 ready" : "R3 ready")),
                   got, exp_rdy);
        hit = 1'b0;
        foreach (wr_q[i]) if (wr_q[i] == a) hit = 1'b1;
        rfree = rdn && (rsp_n > 0);
        wfree = wp && (wr_q.size() > 0);
        exp_rr = rflag && rfree;
        exp_wr = wflag && wfree;
        rej_r = v && !inh && !w && !exp_rdy;
        rej_w = v && !inh && w && !exp_rdy;
        if (rfree) rsp_n--;
        if (rp && rd_q.size() > 0) begin void'(rd_q.pop_front()); rsp_n++; end
        if (wfree) void'(wr_q.pop_front());
        if (v && !inh && exp_rdy) begin
            if (w) begin wr_q.push_back(a); exp_ack++; end
            else if (hit) exp_fwd.push_back(a);
            else rd_q.push_back(a);
        end
        rflag = (rflag && !rfree) || rej_r;
        wflag = (wflag && !wfree) || rej_w;
        @(posedge clk);
        #1;
        req_valid = 1'b0; req_write = 1'b0; req_inh = 1'b0;
        rd_pop = 1'b0; rsp_done = 1'b0; wr_pop = 1'b0;
        @(negedge clk);
        #1;
        chk(rd_retry_o == exp_rr, "R6 read retry", rd_retry_o, exp_rr);
        chk(wr_retry_o == exp_wr, "R7 write retry", wr_retry_o, exp_wr);
        chk(drain_req_o == ((wr_q.size() > WT) && !rd_stall), "R10 drain",
            drain_req_o, (wr_q.size() > WT) && !rd_stall);
        chk(rd_head_valid_o == (rd_q.size() > 0), "R12 read head valid",
            rd_head_valid_o, rd_q.size() > 0);
        if (rd_q.size() > 0) chk(rd_head_addr_o == rd_q[0], "R12 read order", rd_head_addr_o, rd_q[0]);
        chk(wr_head_valid_o == (wr_q.size() > 0), "R12 write head valid",
            wr_head_valid_o, wr_q.size() > 0);
        if (wr_q.size() > 0) chk(wr_head_addr_o == wr_q[0], "R12 write order", wr_head_addr_o, wr_q[0]);
        chk(exp_ack == 0, "R9 missing ack", exp_ack, 0);
        chk(exp_fwd.size() == 0, "R8 missing forward", exp_fwd.size(), 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] a_addr, b_addr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(req_ready_o == 1'b1, "R1 ready", req_ready_o, 1);
        chk(rd_head_valid_o == 1'b0 && wr_head_valid_o == 1'b0, "R1 heads",
            {rd_head_valid_o, wr_head_valid_o}, 0);
        chk({wr_ack_o, rd_fwd_o, rd_retry_o, wr_retry_o, drain_req_o} == 5'b0, "R1 pulses",
            {wr_ack_o, rd_fwd_o, rd_retry_o, wr_retry_o, drain_req_o}, 0);

        // R2: decode of a write
        a_addr = mk(15'h1234, 1, 5, 7'h22, 6'h10);
        cyc(1, 1, 0, a_addr, 0, 0, 0);
        chk(wr_head_row_o == 15'h1234, "R2 row", wr_head_row_o, 15'h1234);
        chk(wr_head_rank_o == 1'b1, "R2 rank", wr_head_rank_o, 1);
        chk(wr_head_bank_o == 3'd5, "R2 bank", wr_head_bank_o, 5);
        chk(wr_head_col_o == 7'h22, "R2 column", wr_head_col_o, 7'h22);

        // R8: read hitting the queued write
        cyc(1, 0, 0, a_addr, 0, 0, 0);
        chk(rd_head_valid_o == 1'b0, "R8 not queued", rd_head_valid_o, 0);

        // R2: decode of a read
        b_addr = mk(15'h0abc, 0, 2, 7'h5, 0);
        cyc(1, 0, 0, b_addr, 0, 0, 0);
        chk(rd_head_row_o == 15'h0abc && rd_head_bank_o == 3'd2 && rd_head_rank_o == 1'b0
            && rd_head_col_o == 7'h5, "R2 read fields",
            {rd_head_row_o, rd_head_rank_o, rd_head_bank_o, rd_head_col_o},
            {15'h0abc, 1'b0, 3'd2, 7'h5});

        // R10: fill writes past the threshold
        for (int i = 1; i <= 5; i++) cyc(1, 1, 0, mk(i, 0, i % 8, 0, 0), 0, 0, 0);
        rd_stall = 1'b1;
        cyc(0, 0, 0, '0, 0, 0, 0);
        rd_stall = 1'b0;
        cyc(0, 0, 0, '0, 0, 0, 0);

        // R4/R5: write side full, then refused, dropped, retried
        cyc(1, 1, 0, mk(6, 0, 1, 1, 0), 0, 0, 0);
        cyc(1, 1, 0, mk(7, 0, 1, 2, 0), 0, 0, 0);
        cyc(1, 1, 0, mk(8, 0, 1, 3, 0), 0, 0, 0);
        cyc(1, 1, 1, mk(9, 0, 1, 3, 0), 0, 0, 0);   // R11 inhibited while full
        cyc(0, 0, 0, '0, 0, 0, 1);                  // R7 retry pulse
        cyc(1, 1, 0, mk(8, 0, 1, 3, 0), 0, 0, 1);   // R12 push with pop
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, '0, 0, 0, 1);
        cyc(0, 0, 0, '0, 0, 0, 1);                  // R12 pop of empty queue

        // R3: read side, queued plus outstanding
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, mk(100 + i, 1, 0, 0, 0), 0, 0, 0);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, '0, 1, 0, 0);
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, mk(200 + i, 0, 3, 0, 0), 0, 0, 0);
        cyc(1, 0, 0, mk(300, 0, 0, 0, 0), 0, 0, 0);   // R5 refused read
        cyc(1, 0, 1, mk(301, 0, 0, 0, 0), 0, 0, 0);   // R11 dropped read
        // R6: refusal and release in one cycle
        cyc(1, 0, 0, mk(302, 0, 0, 0, 0), 0, 1, 0);
        cyc(0, 0, 0, '0, 0, 1, 0);
        cyc(0, 0, 0, '0, 0, 1, 0);
        // accepted read together with a release
        cyc(1, 0, 0, mk(303, 0, 0, 0, 0), 0, 1, 0);
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, '0, 1, 1, 0);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, '0, 0, 1, 0);

        done = 1'b1;
        finish_run();
    end
endmodule